// File: doc/BRIEF.md
# Sub-Word Store Merge Unit

This block stands between a processor's store port and a 32-bit synchronous SRAM. The SRAM can only be read or written one whole word at a time. The processor issues byte, half-word and word stores at byte addresses. Each stored word carries four check bits, and any partial write invalidates them. A store narrower than a word is therefore carried out as a read-modify-write. The unit reads the word that contains the target bytes, replaces only the addressed byte lanes, recomputes the check bits over the merged word, and writes word and check bits back.

A half-word at byte offset 3 spans two adjacent words. The unit handles it with two read-modify-write passes in a row, the second on the next word index. An aligned word store skips the read and is written at once. A word store at a non-zero offset is refused with an error pulse. A request is taken on a valid/ready handshake, and completion is signalled by a one-cycle done pulse.

Top module: `store_merge_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, `req_ready` is 1 and `done`, `err` and `mem_cs` are 0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. After acceptance, `req_ready` is 0 until the cycle after the done or error pulse, when it returns to 1.
- R3: Byte address mapping: the word index is `req_addr[ADDR_W-1:2]` and the byte lane is `req_addr[1:0]`. Storage is little-endian: `req_data[7:0]` goes to the lane named by the address, `req_data[15:8]` to the next lane up, and lane k occupies word bits [8k+7:8k].
- R4: A byte store (`req_size` = 0) reads the containing word in the cycle after acceptance and writes it back in the next cycle. Only the addressed lane changes. `done` is high in the third cycle after acceptance, with one read and one write in total.
- R5: A half-word store (`req_size` = 1) at offset 0, 1 or 2 replaces lanes off and off+1 of one word, with the same timing and access counts as R4.
- R6: A half-word store at offset 3 puts `req_data[7:0]` into lane 3 of word N and `req_data[15:8]` into lane 0 of word N+1. It performs read N, write N, read N+1, write N+1 on consecutive cycles, and `done` is high in the fifth cycle after acceptance. When N is the top index, N+1 wraps to index 0.
- R7: A word store (`req_size` = 2) at offset 0 performs no read. It writes `req_data` in the cycle after acceptance, and `done` is high in the second cycle after acceptance.
- R8: A word store at a non-zero offset, or a request with `req_size` = 3, produces `err` in the cycle after acceptance and no `done`. It makes no SRAM access, so memory is left unchanged.
- R9: On every SRAM write, `mem_wpar[k]` is the XOR of the eight bits of lane k of `mem_wdata` (even parity per lane). For partial stores these bits are computed over the merged word.
- R10: `done` and `err` are single-cycle pulses that are never high together, and `done` directly follows the final SRAM write of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Store request present |
| req_ready | output | 1 | Unit idle and able to accept a store |
| req_addr | input | ADDR_W | Byte address of the store |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| req_data | input | 32 | Store data, right-aligned |
| done | output | 1 | One-cycle pulse when the store is complete |
| err | output | 1 | One-cycle pulse when the request is refused |
| mem_cs | output | 1 | SRAM access enable |
| mem_we | output | 1 | SRAM write (1) or read (0) when `mem_cs` is 1 |
| mem_idx | output | ADDR_W-2 | SRAM word index |
| mem_wdata | output | 32 | Word to write |
| mem_wpar | output | 4 | Per-lane check bits to write |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |

## Verification
The hardest case to reach is the boundary-crossing half-word at the highest word index. There, the second pass must wrap to index 0 and leave lanes 1 to 3 of that word intact. The bench aims directed stores at index 255 offset 3 and at a mid-array offset 3. It then compares every word and its check bits against a byte-array model, which catches a merge into the wrong lane or a stale value in either pass. Randomised stores over the whole address range follow. They mix all sizes and offsets, so split, aligned and refused requests arrive back to back straight after one another's completion.

// File: rtl/smu_pkg.sv
package smu_pkg;

    localparam int WORD_W = 32;
    localparam int LANE_W = 8;
    localparam int LANES  = WORD_W / LANE_W;
    localparam int OFF_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD1,
        ST_WR1,
        ST_RD2,
        ST_WR2,
        ST_DONE,
        ST_ERR
    } state_e;

    typedef struct packed {
        size_e              size;
        logic [OFF_W-1:0]   off;
        logic [WORD_W-1:0]  data;
    } store_t;

    // Lanes touched in the first (or only) word of a store.
    function automatic logic [LANES-1:0] lane_mask(size_e sz, logic [OFF_W-1:0] off);
        logic [LANES-1:0] m;
        case (sz)
            SZ_BYTE: m = LANES'(1) << off;
            SZ_HALF: m = (off == OFF_W'(LANES - 1)) ? (LANES'(1) << off)
                                                   : (LANES'(3) << off);
            SZ_WORD: m = '1;
            default: m = '0;
        endcase
        return m;
    endfunction

    function automatic logic straddles(size_e sz, logic [OFF_W-1:0] off);
        return (sz == SZ_HALF) && (off == OFF_W'(LANES - 1));
    endfunction

    function automatic logic refused(size_e sz, logic [OFF_W-1:0] off);
        return (sz == SZ_RSVD) || ((sz == SZ_WORD) && (off != '0));
    endfunction

endpackage

// File: rtl/smu_parity_gen.sv
module smu_parity_gen
    import smu_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic [LANES-1:0]  par
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign par[g] = ^word[g*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/smu_lane_merge.sv
module smu_lane_merge
    import smu_pkg::*;
(
    input  logic              second,
    input  store_t            st,
    input  logic [WORD_W-1:0] old_word,
    output logic [WORD_W-1:0] new_word,
    output logic [LANES-1:0]  new_par
);
    logic [LANES-1:0]  mask;
    logic [WORD_W-1:0] placed;

    always_comb begin
        if (second) begin
            mask   = LANES'(1);
            placed = WORD_W'(st.data[2*LANE_W-1:LANE_W]);
        end else begin
            mask   = lane_mask(st.size, st.off);
            placed = st.data << {st.off, 3'b000};
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_sel
        assign new_word[g*LANE_W +: LANE_W] = mask[g] ? placed[g*LANE_W +: LANE_W]
                                                      : old_word[g*LANE_W +: LANE_W];
    end

    smu_parity_gen u_par (
        .word (new_word),
        .par  (new_par)
    );
endmodule

// File: rtl/smu_ctrl.sv
module smu_ctrl
    import smu_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [IDX_W-1:0] in_idx,
    input  store_t           in_st,
    output logic             req_ready,
    output logic             done,
    output logic             err,
    output logic             mem_cs,
    output logic             mem_we,
    output logic [IDX_W-1:0] mem_idx,
    output logic             second,
    output store_t           held
);
    localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

    state_e           state, nxt;
    logic [IDX_W-1:0] base_idx;
    logic             take;

    assign take = req_valid && (state == ST_IDLE);

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE: if (take) begin
                if (refused(in_st.size, in_st.off))  nxt = ST_ERR;
                else if (in_st.size == SZ_WORD)      nxt = ST_WR1;
                else                                 nxt = ST_RD1;
            end
            ST_RD1:  nxt = ST_WR1;
            ST_WR1:  nxt = straddles(held.size, held.off) ? ST_RD2 : ST_DONE;
            ST_RD2:  nxt = ST_WR2;
            ST_WR2:  nxt = ST_DONE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            base_idx <= '0;
            held     <= '0;
        end else begin
            state <= nxt;
            if (take) begin
                base_idx <= in_idx;
                held     <= in_st;
            end
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign done      = (state == ST_DONE);
    assign err       = (state == ST_ERR);
    assign mem_cs    = (state == ST_RD1) || (state == ST_WR1) ||
                       (state == ST_RD2) || (state == ST_WR2);
    assign mem_we    = (state == ST_WR1) || (state == ST_WR2);
    assign second    = (state == ST_RD2) || (state == ST_WR2);
    assign mem_idx   = second ? base_idx + IDX_ONE : base_idx;

    AST_SPLIT_NEXT_IDX: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD2) |-> (mem_idx == $past(mem_idx) + IDX_ONE)); // R6
    AST_PARTIAL_READ_FIRST: assert property (@(posedge clk) disable iff (rst)
        (mem_cs && mem_we && held.size != SZ_WORD) |-> $past(mem_cs && !mem_we)); // R4
    AST_WORD_NO_READ: assert property (@(posedge clk) disable iff (rst)
        (mem_cs && !mem_we) |-> (held.size != SZ_WORD)); // R7
endmodule

// File: rtl/store_merge_unit.sv
module store_merge_unit
    import smu_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [1:0]          req_size,
    input  logic [WORD_W-1:0]   req_data,
    output logic                done,
    output logic                err,
    output logic                mem_cs,
    output logic                mem_we,
    output logic [ADDR_W-3:0]   mem_idx,
    output logic [WORD_W-1:0]   mem_wdata,
    output logic [LANES-1:0]    mem_wpar,
    input  logic [WORD_W-1:0]   mem_rdata
);
    localparam int IDX_W = ADDR_W - OFF_W;

    store_t in_st, held;
    logic   second;

    assign in_st.size = size_e'(req_size);
    assign in_st.off  = req_addr[OFF_W-1:0];
    assign in_st.data = req_data;

    smu_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .in_idx    (req_addr[ADDR_W-1:OFF_W]),
        .in_st     (in_st),
        .req_ready (req_ready),
        .done      (done),
        .err       (err),
        .mem_cs    (mem_cs),
        .mem_we    (mem_we),
        .mem_idx   (mem_idx),
        .second    (second),
        .held      (held)
    );

    smu_lane_merge u_merge (
        .second   (second),
        .st       (held),
        .old_word (mem_rdata),
        .new_word (mem_wdata),
        .new_par  (mem_wpar)
    );

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready); // R2
    AST_WRITE_PARITY: assert property (@(posedge clk) disable iff (rst)
        (mem_cs && mem_we) |-> (mem_wpar == {^mem_wdata[31:24], ^mem_wdata[23:16],
                                             ^mem_wdata[15:8],  ^mem_wdata[7:0]})); // R9
    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(mem_cs && mem_we)); // R10
    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done && err)); // R10
    AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
        err |-> (!mem_cs && $past(req_valid && req_ready))); // R8
endmodule

// File: tb/sim_store_merge_unit.sv
module sim_store_merge_unit;
    localparam int ADDR_W = 10;
    localparam int NW = 1 << (ADDR_W - 2);
    localparam int NB = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        req_size = '0;
    logic [31:0]       req_data = '0;
    logic              done, err, mem_cs, mem_we;
    logic [ADDR_W-3:0] mem_idx;
    logic [31:0]       mem_wdata, mem_rdata;
    logic [3:0]        mem_wpar;

    logic [31:0] sram [NW];
    logic [3:0]  spar [NW];
    logic [7:0]  refb [NB];
    int rd_cnt = 0, wr_cnt = 0, n_chk = 0, n_fail = 0, cyc = 0;

    always #5 clk = ~clk;

    store_merge_unit #(.ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_data(req_data),
        .done(done), .err(err), .mem_cs(mem_cs), .mem_we(mem_we),
        .mem_idx(mem_idx), .mem_wdata(mem_wdata), .mem_wpar(mem_wpar),
        .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_cs && mem_we) begin
            sram[mem_idx] <= mem_wdata;
            spar[mem_idx] <= mem_wpar;
            wr_cnt <= wr_cnt + 1;
        end else if (mem_cs) begin
            mem_rdata <= sram[mem_idx];
            rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL R2 watchdog: actual %0d cycles expected completion", cyc);
            summary();
            $finish;
        end
    end

    function automatic logic [3:0] par_of(input logic [31:0] w);
        return {^w[31:24], ^w[23:16], ^w[15:8], ^w[7:0]};
    endfunction

    function automatic logic [31:0] ref_word(input int w);
        return {refb[4*w+3], refb[4*w+2], refb[4*w+1], refb[4*w]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_mem(input string req);
        int bad_w = -1;
        int bad_p = -1;
        for (int w = 0; w < NW; w++) begin
            if (bad_w < 0 && sram[w] !== ref_word(w)) bad_w = w;
            if (bad_p < 0 && spar[w] !== par_of(ref_word(w))) bad_p = w;
        end
        if (bad_w < 0) chk(1'b1, req, "memory contents", 32'h0, 32'h0);
        else chk(1'b0, req, $sformatf("memory word %0d", bad_w), sram[bad_w], ref_word(bad_w));
        if (bad_p < 0) chk(1'b1, "R9", "check bits", 32'h0, 32'h0);
        else chk(1'b0, "R9", $sformatf("check bits word %0d", bad_p),
                 32'(spar[bad_p]), 32'(par_of(ref_word(bad_p))));
    endtask

    task automatic ref_apply(input logic [ADDR_W-1:0] a, input logic [1:0] sz, input logic [31:0] d);
        int b = int'(a);
        case (sz)
            2'd0: refb[b] = d[7:0];
            2'd1: begin refb[b] = d[7:0]; refb[(b + 1) % NB] = d[15:8]; end
            default: for (int k = 0; k < 4; k++) refb[b + k] = d[8*k +: 8];
        endcase
    endtask

    task automatic run_store(input logic [ADDR_W-1:0] a, input logic [1:0] sz, input logic [31:0] d,
                             input string req, input int exp_lat, input int exp_rd,
                             input int exp_wr, input bit exp_err);
        int lat;
        int r0, w0;
        bit busy_ok, seen_err, seen_done;
        r0 = rd_cnt; w0 = wr_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1; busy_ok = 1'b1;
        while (!done && !err && lat < 20) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
            lat++;
        end
        if (req_ready) busy_ok = 1'b0;
        seen_err = err; seen_done = done;
        @(negedge clk);
        chk(lat == exp_lat, req, "cycles to completion", 32'(lat), 32'(exp_lat));
        chk(seen_err == exp_err, "R8", "error pulse", 32'(seen_err), 32'(exp_err));
        chk(seen_done == !exp_err, "R10", "done pulse", 32'(seen_done), 32'(!exp_err));
        chk(busy_ok, "R2", "ready low while busy", 32'(busy_ok), 32'd1);
        chk(!done && !err && req_ready, "R10", "single-cycle pulse then ready",
            {29'd0, done, err, req_ready}, 32'd1);
        chk(rd_cnt - r0 == exp_rd, req, "read count", 32'(rd_cnt - r0), 32'(exp_rd));
        chk(wr_cnt - w0 == exp_wr, req, "write count", 32'(wr_cnt - w0), 32'(exp_wr));
        if (!exp_err) ref_apply(a, sz, d);
        chk_mem(req);
    endtask

    task automatic run_auto(input logic [ADDR_W-1:0] a, input logic [1:0] sz, input logic [31:0] d);
        if (sz == 2'd3 || (sz == 2'd2 && a[1:0] != 2'd0)) run_store(a, sz, d, "R8", 1, 0, 0, 1'b1);
        else if (sz == 2'd2) run_store(a, sz, d, "R7", 2, 0, 1, 1'b0);
        else if (sz == 2'd1 && a[1:0] == 2'd3) run_store(a, sz, d, "R6", 5, 2, 2, 1'b0);
        else if (sz == 2'd1) run_store(a, sz, d, "R5", 3, 1, 1, 1'b0);
        else run_store(a, sz, d, "R4", 3, 1, 1, 1'b0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(req_ready && !done && !err && !mem_cs, "R1", "outputs in reset",
            {28'd0, req_ready, done, err, mem_cs}, 32'h8);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && !done && !err && !mem_cs, "R1", "outputs after reset",
            {28'd0, req_ready, done, err, mem_cs}, 32'h8);
    endtask

    task automatic t_byte();
        for (int k = 0; k < 4; k++) run_store(ADDR_W'(5*4 + k), 2'd0, 32'hFFFF_FF10 + 32'(k), "R4", 3, 1, 1, 1'b0);
        run_store(ADDR_W'(5*4 + 2), 2'd0, 32'h0000_00AB, "R4", 3, 1, 1, 1'b0);
        chk(sram[5][23:16] == 8'hAB, "R3", "lane 2 little-endian", 32'(sram[5][23:16]), 32'hAB);
    endtask

    task automatic t_half();
        for (int k = 0; k < 3; k++) run_store(ADDR_W'(9*4 + k), 2'd1, 32'h5A5A_C300 + 32'(k), "R5", 3, 1, 1, 1'b0);
        chk(sram[9][31:24] == 8'hC3, "R3", "upper half-word byte order", 32'(sram[9][31:24]), 32'hC3);
    endtask

    task automatic t_split();
        run_store(ADDR_W'(20*4 + 3), 2'd1, 32'h0000_E17D, "R6", 5, 2, 2, 1'b0);
        chk(sram[20][31:24] == 8'h7D && sram[21][7:0] == 8'hE1, "R6", "split lanes",
            {16'd0, sram[21][7:0], sram[20][31:24]}, 32'hE17D);
    endtask

    task automatic t_split_top();
        run_store(ADDR_W'((NW-1)*4 + 3), 2'd1, 32'h0000_3C96, "R6", 5, 2, 2, 1'b0);
        chk(sram[0][7:0] == 8'h3C, "R6", "wrap to index 0", 32'(sram[0][7:0]), 32'h3C);
    endtask

    task automatic t_word();
        run_store(ADDR_W'(33*4), 2'd2, 32'hDEAD_BEEF, "R7", 2, 0, 1, 1'b0);
        run_store(ADDR_W'((NW-1)*4), 2'd2, 32'h0123_4567, "R7", 2, 0, 1, 1'b0);
    endtask

    task automatic t_refused();
        for (int k = 1; k < 4; k++) run_store(ADDR_W'(40*4 + k), 2'd2, 32'hBAD0_0000, "R8", 1, 0, 0, 1'b1);
        run_store(ADDR_W'(41*4), 2'd3, 32'hBAD1_1111, "R8", 1, 0, 0, 1'b1);
    endtask

    task automatic t_random();
        for (int n = 0; n < 60; n++)
            run_auto(ADDR_W'($urandom_range(0, NB-1)), 2'($urandom_range(0, 3)), $urandom());
        for (int n = 0; n < 8; n++)
            run_auto(ADDR_W'(($urandom_range(0, NW-1) * 4) + 3), 2'd1, $urandom());
    endtask

    initial begin
        for (int w = 0; w < NW; w++) begin
            sram[w] = (32'(w) * 32'h0101_0101) ^ 32'hA5C3_0F96;
            spar[w] = par_of(sram[w]);
            for (int k = 0; k < 4; k++) refb[4*w + k] = sram[w][8*k +: 8];
        end
        t_reset();
        t_byte();
        t_half();
        t_split();
        t_split_top();
        t_word();
        t_refused();
        t_random();
        summary();
        $finish;
    end
endmodule